// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This unit turns a bank of general-purpose input pins into interrupt requests. Every pin samples its input through a two-flop synchronizer. Each pin then runs in one of two modes, chosen per pin:

- **Level mode:** the pin reports its present level, after polarity adjustment.
- **Edge mode:** the pin records a transition in a sticky flag bit, which stays set until software clears it.

The unit provides one flag bit per pin. A masked view of those flags is driven out per pin, and the OR of that masked view forms a single bank interrupt. That bank interrupt feeds an interrupt controller further downstream.

Software uses a small register port to configure the unit. Five configuration words hold the following bits per pin:

| Word | Meaning when the bit is 1 |
|------|---------------------------|
| enable | the pin may sense |
| sense-edge | edge mode; 0 selects level mode |
| any-edge | an edge-mode pin reacts to both edges |
| invert | active-low level or falling edge |
| unmask | the pin may drive the interrupt |

A sixth word is the flag word. Software reads it, and writes to it only to clear latched edge flags.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset every configuration word, the flag word, every bit of pin_flag_o and irq_o read 0.
- R2: Register addresses are 0 for flags, 1 for enable, 2 for sense-edge, 3 for any-edge, 4 for invert and 5 for unmask. A write to addresses 1 to 5 is read back unchanged from the same address in the next cycle. Reads are combinational.
- R3: An enabled level-mode pin (sense-edge bit 0) shows a flag equal to the synchronized pin value XOR its invert bit. Writes to the flag word do not change it.
- R4: An enabled edge-mode pin with invert 0 and any-edge 0 sets its flag on a 0-to-1 input transition. The flag stays set after the input returns to 0. A 1-to-0 transition does not set it.
- R5: An enabled edge-mode pin with invert 1 and any-edge 0 sets its flag on a 1-to-0 transition only.
- R6: An enabled edge-mode pin with any-edge 1 sets its flag on either transition, whatever its invert bit holds.
- R7: For edge-mode pins, a write to address 0 clears each flag whose written bit is 0. A flag whose written bit is 1 keeps its value.
- R8: When a new edge event and a clearing write reach the same pin in the same cycle, the flag ends up set.
- R9: A pin whose enable bit is 0 holds its flag at 0 in both modes and latches no event.
- R10: pin_flag_o is the flag word ANDed with the unmask word. irq_o is 1 exactly when pin_flag_o is nonzero.
- R11: A pin change driven between clock edges reaches the flag word on the third following rising clock edge, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 16 | Asynchronous pin inputs of the bank |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data, one bit per pin |
| reg_rdata | output | 16 | Read data of the addressed register |
| pin_flag_o | output | 16 | Flag bits ANDed with the unmask bits |
| irq_o | output | 1 | Bank interrupt, OR of pin_flag_o |

## Verification
The bench builds the unit with its defaults: a 16-pin bank and two synchronizer stages. This fixes the pin-to-flag latency at exactly three edges, so R11 can be checked edge by edge. All pin-level stimulus goes to pin 3 while the other pins stay idle and disabled. A failure in the per-pin generate indexing or a leak between neighbouring pins therefore shows up in the full 16-bit flag and interrupt values. The same-cycle event and clear case is set up by counting edges so that both land on the third edge.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_FLAGS  = 3'd0,
    REG_ENABLE = 3'd1,
    REG_EDGE   = 3'd2,
    REG_ANY    = 3'd3,
    REG_INVERT = 3'd4,
    REG_UNMASK = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  // Stage 0 samples the pins; every later stage samples the one before it.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_sense_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      enable_q,
  output logic [WIDTH-1:0]      edge_q,
  output logic [WIDTH-1:0]      any_q,
  output logic [WIDTH-1:0]      invert_q,
  output logic [WIDTH-1:0]      unmask_q
);
  localparam int unsigned NCFG = 5;

  logic [NCFG-1:0]            sel;
  logic [NCFG-1:0][WIDTH-1:0] cfg_q;
  logic [NCFG-1:0][WIDTH-1:0] cfg_d;

  // One word per configuration address, 1..NCFG; each has its own clock enable.
  generate
    for (genvar k = 0; k < NCFG; k++) begin : g_word
      assign sel[k] = wr_en && (addr == REG_ADDR_W'(k + 1));

      always_comb begin
        cfg_d[k] = cfg_q[k];
        if (sel[k]) cfg_d[k] = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q[k] <= '0;
        else if (sel[k]) cfg_q[k] <= cfg_d[k];
      end
    end
  endgenerate

  assign enable_q = cfg_q[0];
  assign edge_q   = cfg_q[1];
  assign any_q    = cfg_q[2];
  assign invert_q = cfg_q[3];
  assign unmask_q = cfg_q[4];
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] enable_i,
  input  logic [WIDTH-1:0] edge_i,
  input  logic [WIDTH-1:0] any_i,
  input  logic [WIDTH-1:0] invert_i,
  input  logic             clr_wr_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] flag_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_d;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall, hit;

      assign rise = sync_i[i] & ~prev_q[i];
      assign fall = ~sync_i[i] & prev_q[i];
      assign hit  = any_i[i] ? (rise | fall) : (invert_i[i] ? fall : rise);

      // Order of the branches sets the priority: enable, then mode,
      // then a new event ahead of a software clear.
      always_comb begin
        if (!enable_i[i])                     flag_d[i] = 1'b0;
        else if (!edge_i[i])                  flag_d[i] = sync_i[i] ^ invert_i[i];
        else if (hit)                         flag_d[i] = 1'b1;
        else if (clr_wr_i && !clr_data_i[i])  flag_d[i] = 1'b0;
        else                                  flag_d[i] = flag_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= sync_i;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank
  import gpio_sense_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDTH-1:0]      pin_i,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_we,
  input  logic [WIDTH-1:0]      reg_wdata,
  output logic [WIDTH-1:0]      reg_rdata,
  output logic [WIDTH-1:0]      pin_flag_o,
  output logic                  irq_o
);
  logic             rst_meta_q, rst_core_n;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] enable_q, edge_q, any_q, invert_q, unmask_q;
  logic [WIDTH-1:0] data_q;
  logic             flag_wr;

  // Reset is asserted at once and released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  gpio_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .enable_q (enable_q),
    .edge_q   (edge_q),
    .any_q    (any_q),
    .invert_q (invert_q),
    .unmask_q (unmask_q)
  );

  assign flag_wr = reg_we && (reg_sel_e'(reg_addr) == REG_FLAGS);

  gpio_pin_sense #(.WIDTH(WIDTH)) u_sense (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sync_i     (pin_sync),
    .enable_i   (enable_q),
    .edge_i     (edge_q),
    .any_i      (any_q),
    .invert_i   (invert_q),
    .clr_wr_i   (flag_wr),
    .clr_data_i (reg_wdata),
    .flag_q     (data_q)
  );

  always_comb begin
    case (reg_sel_e'(reg_addr))
      REG_FLAGS:  reg_rdata = data_q;
      REG_ENABLE: reg_rdata = enable_q;
      REG_EDGE:   reg_rdata = edge_q;
      REG_ANY:    reg_rdata = any_q;
      REG_INVERT: reg_rdata = invert_q;
      REG_UNMASK: reg_rdata = unmask_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign pin_flag_o = data_q & unmask_q;
  assign irq_o      = |pin_flag_o;
endmodule

// File: rtl/gpio_sense_bank_chk.sv
module gpio_sense_bank_chk
  import gpio_sense_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [WIDTH-1:0]      reg_wdata,
  input logic [WIDTH-1:0]      pin_sync,
  input logic [WIDTH-1:0]      data_q,
  input logic [WIDTH-1:0]      enable_q,
  input logic [WIDTH-1:0]      edge_q,
  input logic [WIDTH-1:0]      invert_q,
  input logic [WIDTH-1:0]      pin_flag_o,
  input logic                  irq_o
);
  logic [WIDTH-1:0] keep_bits;

  assign keep_bits = (reg_we && reg_addr == REG_FLAGS) ? reg_wdata : '1;

  // A disabled pin has a clear flag one cycle later.
  assert_disabled_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q & ~$past(enable_q)) == '0));

  // An enabled level-mode pin follows the synchronized input XOR invert.
  assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(pin_sync ^ invert_q)) & $past(enable_q & ~edge_q)) == '0));

  // A latched edge flag survives unless a write clears it.
  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(data_q & edge_q & enable_q & keep_bits) & ~data_q) == '0));

  // The bank interrupt tracks the masked flags.
  assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pin_flag_o != '0));

  // No masked flag can exist without a set flag bit.
  assert_flag_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_flag_o & ~data_q) == '0);
endmodule

bind gpio_sense_bank gpio_sense_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .pin_sync   (pin_sync),
  .data_q     (data_q),
  .enable_q   (enable_q),
  .edge_q     (edge_q),
  .invert_q   (invert_q),
  .pin_flag_o (pin_flag_o),
  .irq_o      (irq_o)
);

// File: tb/gpio_sense_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_sense_bank_tb_top;
  localparam int W   = 16;
  localparam int PIN = 3;
  localparam logic [W-1:0] PBIT = W'(1) << PIN;

  // Each entry: {sense-edge, any-edge, invert, start level, end level, expected flag}
  localparam int NVEC = 11;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000_01_1, 6'b000_10_0, 6'b001_10_1, 6'b001_01_0,
    6'b100_01_1, 6'b100_10_0, 6'b101_10_1, 6'b101_01_0,
    6'b110_10_1, 6'b111_01_1, 6'b100_00_0
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] pin_i;
  logic [2:0]   reg_addr;
  logic         reg_we;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pin_flag_o;
  logic         irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_sense_bank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pin_flag_o (pin_flag_o),
    .irq_o      (irq_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin_i[PIN] = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    rst_n = 1'b0; pin_i = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      check("R1 reset register", r, '0);
    end
    check("R1 reset flags out", pin_flag_o, '0);
    check("R1 reset irq", W'(irq_o), '0);

    // R2 readback
    for (int a = 1; a < 6; a++) begin
      wr(3'(a), 16'hA5C3 ^ W'(a));
      rd(3'(a), r);
      check("R2 readback", r, 16'hA5C3 ^ W'(a));
      wr(3'(a), '0);
    end

    // Vector table on pin PIN: R3 level, R4 rising, R5 falling, R6 any edge, R10 irq
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] e;
      e = VEC[v];
      wr(3'd1, '0);
      set_pin(e[2]);
      wr(3'd2, e[5] ? PBIT : '0);
      wr(3'd3, e[4] ? PBIT : '0);
      wr(3'd4, e[3] ? PBIT : '0);
      wr(3'd5, PBIT);
      wr(3'd1, PBIT);
      repeat (3) @(posedge clk);
      wr(3'd0, '0);
      set_pin(e[1]);
      rd(3'd0, r);
      check(e[5] ? (e[4] ? "R6 any edge" : (e[3] ? "R5 falling" : "R4 rising")) : "R3 level",
            r, e[0] ? PBIT : '0);
      check("R10 irq from table", W'(irq_o), W'(e[0]));
      check("R10 flags out", pin_flag_o, e[0] ? PBIT : '0);
    end

    // R4 stays latched after the input returns to 0; R7 write 1 keeps, write 0 clears
    wr(3'd1, '0); set_pin(1'b0);
    wr(3'd2, PBIT); wr(3'd3, '0); wr(3'd4, '0); wr(3'd1, PBIT);
    set_pin(1'b1); set_pin(1'b0);
    rd(3'd0, r); check("R4 latched after return", r, PBIT);
    wr(3'd0, '1);
    rd(3'd0, r); check("R7 write 1 keeps", r, PBIT);
    wr(3'd0, ~PBIT);
    rd(3'd0, r); check("R7 write 0 clears", r, '0);

    // R3 writes have no effect on a level pin
    wr(3'd2, '0); set_pin(1'b1);
    wr(3'd0, '0);
    rd(3'd0, r); check("R3 level ignores clear", r, PBIT);

    // R11 latency, rising edge pin
    set_pin(1'b0); wr(3'd2, PBIT); wr(3'd0, '0);
    @(negedge clk) pin_i[PIN] = 1'b1;
    reg_addr = 3'd0;
    @(posedge clk); @(posedge clk); #1;
    check("R11 not after second edge", reg_rdata, '0);
    @(posedge clk); #1;
    check("R11 after third edge", reg_rdata, PBIT);

    // R8 event and clear in the same cycle, any-edge pin
    wr(3'd3, PBIT);
    repeat (3) @(posedge clk);
    @(negedge clk) pin_i[PIN] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 3'd0; reg_we = 1'b1; reg_wdata = '0;
    @(negedge clk); reg_we = 1'b0;
    rd(3'd0, r); check("R8 event beats clear", r, PBIT);

    // R10 masked pin: flag set, no interrupt
    wr(3'd5, '0);
    rd(3'd0, r); check("R10 flag kept while masked", r, PBIT);
    check("R10 masked irq", W'(irq_o), '0);
    check("R10 masked flags out", pin_flag_o, '0);

    // R9 disabled pin, both modes
    wr(3'd5, PBIT); wr(3'd1, '0);
    set_pin(1'b1); set_pin(1'b0);
    rd(3'd0, r); check("R9 disabled edge pin", r, '0);
    wr(3'd2, '0); set_pin(1'b1);
    rd(3'd0, r); check("R9 disabled level pin", r, '0);
    check("R9 disabled irq", W'(irq_o), '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule